// File: doc/BRIEF.md
# Policy-Configurable Countdown Timer

This block is a down-counter that advances on an external tick enable. It can be disabled, run periodically, or run once. Software-style strobes load the count, load the reload limit (with or without copying it into the count), set a tick interval, start the timer in either running mode, and stop it. When the remaining count runs out, the block emits a one-cycle trigger pulse. In periodic mode it then reloads from the limit. In one-shot mode it clears the count and returns to disabled.

A five-bit policy word is captured while reset is held and stays fixed afterwards. It changes the corner cases:
- what happens when the count is zero at a reload,
- whether a wrap holds zero for an extra step,
- whether a zero limit triggers on every step,
- whether the read-back count is rounded down.

The tick interval divides incoming ticks. One count step takes `interval` accepted ticks. An interval of zero stops the timer.

The block has no data stream, so every pin is plain control or status. Commands are single-cycle strobes, at most one per cycle. If several arrive together, the order of precedence is stop, interval, count, limit, run. The live count is always presented on `count_o`.

Top module: `pdt_timer`

## Requirements
- R1: After reset, the mode is disabled (`mode_o` = 0), `count_o` is 0, `trig_o` is 0, the limit is 0 and the tick interval is 1. The policy word is captured while `rst_i` is high. Its bits are: 0 = no immediate trigger, 1 = no immediate reload, 2 = wrap after one extra step, 3 = continuous trigger, 4 = no round-down.
- R2: A run strobe selects periodic mode (`mode_o` = 1) when `run_once_i` = 0 and one-shot mode (`mode_o` = 2) when `run_once_i` = 1. When a one-shot timer expires, the count becomes 0, the mode returns to 0 and one trigger is emitted.
- R3: One step takes `interval` accepted ticks. When a periodic timer expires, the count reloads from the limit and a trigger is emitted.
- R4: Setting an interval of 0 while running latches the read-back count and disables the timer. A run strobe while disabled with an interval of 0 is ignored.
- R5: When a reload or start finds the count at zero, a trigger is emitted in the same event, unless policy bit 0 is set.
- R6: When a reload finds the count at zero, the count takes the limit, unless policy bit 1 is set. With bit 1 set, a periodic timer with a nonzero limit waits one step and then reloads. That deferred reload emits no trigger unless bit 0 is set.
- R7: With policy bit 2, each periodic period after an expiry lasts limit+1 steps. In that period the read-back is 0 while the floored remainder equals limit+1 (no tick accepted since the reload) or equals the limit (after a tick).
- R8: With policy bit 3, a periodic timer with a zero limit triggers on every step and stays enabled.
- R9: If the remaining step count is zero after all policy adjustments, the timer disables itself. An enabled timer always has a nonzero remainder.
- R10: A stop strobe latches the read-back count and disables the timer. A limit strobe copies its value into the count only when `limit_reload_i` = 1.
- R11: The read-back while enabled with a nonzero count is the remaining steps, less one if the tick interval is part-way through a step. With policy bit 4, one is added, except when no tick has been accepted since the last reload.
- R12: A command strobe takes precedence over a tick in the same cycle, and that tick is discarded. At most one command strobe is high in any cycle.
- R13: `trig_o` is registered. It goes high in the cycle after the expiry or reload event that caused it, for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; policy captured while high |
| policy_i | input | 5 | Policy word (see R1 for bit meanings) |
| tick_i | input | 1 | Tick enable |
| cmd_run_i | input | 1 | Run strobe |
| run_once_i | input | 1 | With run: 1 = one-shot, 0 = periodic |
| cmd_stop_i | input | 1 | Stop strobe |
| cmd_count_i | input | 1 | Load count from `wdata_i` |
| cmd_limit_i | input | 1 | Load limit from `wdata_i` |
| limit_reload_i | input | 1 | With limit strobe: also load the count |
| cmd_period_i | input | 1 | Load tick interval from `period_i` |
| wdata_i | input | CNT_W | Count or limit value |
| period_i | input | PER_W | Tick interval value |
| count_o | output | CNT_W | Read-back count |
| mode_o | output | 2 | Current mode: 0 disabled, 1 periodic, 2 one-shot |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench builds the block with CNT_W = 8 and PER_W = 3. Limits near the top of the range and the limit+1 wrap period therefore fit in a few hundred cycles. Intervals of 1 to 7 exercise the part-way-through-a-step rounding. Each policy bit is enabled in turn by resetting with a new policy word. This covers:
- the deferred reload,
- the zero-limit continuous trigger,
- the self-disable,
- the held-zero wrap.

A behavioural model is compared with the outputs on every clock.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } mode_e;

  // How a reload adjusts the step count (wrap policy)
  typedef enum logic [1:0] {
    ADJ_ZERO = 2'd0,
    ADJ_PLUS = 2'd1,
    ADJ_NONE = 2'd2
  } adj_e;

  localparam int POL_W = 5;

  // bit 4 .. bit 0
  typedef struct packed {
    logic no_round;
    logic cont;
    logic wrap;
    logic no_imm_reload;
    logic no_imm_trig;
  } pol_t;
endpackage

// File: rtl/pdt_reload.sv
module pdt_reload
  import pdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lim_i,
  input  mode_e            mode_i,
  input  logic             per_zero_i,
  input  adj_e             adj_i,
  input  pol_t             pol_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W:0]   rem_o,
  output logic             off_o,
  output logic             trig_o
);
  logic [CNT_W:0] d;

  always_comb begin
    trig_o = (cnt_i == '0) && !pol_i.no_imm_trig;
    cnt_o  = cnt_i;
    if (cnt_i == '0 && !pol_i.no_imm_reload) cnt_o = lim_i;
    d = {1'b0, cnt_o};
    if (pol_i.wrap && adj_i == ADJ_PLUS) d = d + 1'b1;
    if (d == '0 && pol_i.cont && mode_i == MODE_PERIODIC && lim_i == '0)
      d = {{CNT_W{1'b0}}, 1'b1};
    if (d == '0 && pol_i.no_imm_trig && adj_i != ADJ_NONE)
      d = {{CNT_W{1'b0}}, 1'b1};
    if (d == '0 && pol_i.no_imm_reload && mode_i == MODE_PERIODIC && lim_i != '0)
      d = {{CNT_W{1'b0}}, 1'b1};
    off_o = per_zero_i || (d == '0);
    rem_o = d;
  end
endmodule

// File: rtl/pdt_readback.sv
module pdt_readback
  import pdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic [CNT_W:0]   rem_i,
  input  logic             part_i,
  input  logic             fresh_i,
  input  pol_t             pol_i,
  output logic [CNT_W-1:0] val_o
);
  logic [CNT_W:0] floor_v;
  logic           hold_zero;
  logic           bump;

  always_comb begin
    floor_v   = rem_i - {{CNT_W{1'b0}}, part_i};
    hold_zero = pol_i.wrap && mode_i == MODE_PERIODIC && cnt_i == lim_i &&
                (fresh_i ? (floor_v == {1'b0, lim_i} + 1'b1)
                         : (floor_v == {1'b0, lim_i}));
    bump      = pol_i.no_round && !fresh_i;
    if (mode_i != MODE_OFF && cnt_i != '0) begin
      if (hold_zero) val_o = '0;
      else           val_o = floor_v[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, bump};
    end else begin
      val_o = cnt_i;
    end
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [POL_W-1:0]   policy_i,
  input  logic               tick_i,
  input  logic               cmd_run_i,
  input  logic               run_once_i,
  input  logic               cmd_stop_i,
  input  logic               cmd_count_i,
  input  logic               cmd_limit_i,
  input  logic               limit_reload_i,
  input  logic               cmd_period_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [PER_W-1:0]   period_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [1:0]         mode_o,
  output logic               trig_o
);
  localparam int REM_W = CNT_W + 1;

  mode_e            mode_q, a_mode, n_mode;
  logic [CNT_W-1:0] cnt_q, a_cnt, n_cnt;
  logic [CNT_W-1:0] lim_q, a_lim;
  logic [PER_W-1:0] per_q, a_per;
  logic [PER_W-1:0] pc_q, a_pc, n_pc;
  logic [REM_W-1:0] rem_q, a_rem, n_rem;
  logic             fresh_q, a_fresh, n_fresh;
  logic             trig_q, a_trig, n_trig;
  pol_t             pol_q;

  logic             rl_go;
  adj_e             rl_adj;
  logic [CNT_W-1:0] rl_cnt;
  logic [REM_W-1:0] rl_rem;
  logic             rl_off, rl_trig;
  logic [CNT_W-1:0] rb;

  pdt_readback #(.CNT_W(CNT_W)) u_rb (
    .mode_i (mode_q), .cnt_i (cnt_q), .lim_i (lim_q), .rem_i (rem_q),
    .part_i (pc_q != '0), .fresh_i (fresh_q), .pol_i (pol_q), .val_o (rb)
  );

  // Stage A: command or tick decode
  always_comb begin
    a_mode  = mode_q;
    a_cnt   = cnt_q;
    a_lim   = lim_q;
    a_per   = per_q;
    a_pc    = pc_q;
    a_rem   = rem_q;
    a_fresh = fresh_q;
    a_trig  = 1'b0;
    rl_go   = 1'b0;
    rl_adj  = ADJ_ZERO;
    if (cmd_stop_i) begin
      if (mode_q != MODE_OFF) begin
        a_cnt  = rb;
        a_mode = MODE_OFF;
      end
    end else if (cmd_period_i) begin
      a_cnt = rb;
      a_per = period_i;
      rl_go = (mode_q != MODE_OFF);
    end else if (cmd_count_i) begin
      a_cnt = wdata_i;
      rl_go = (mode_q != MODE_OFF);
    end else if (cmd_limit_i) begin
      a_lim = wdata_i;
      if (limit_reload_i) begin
        a_cnt = wdata_i;
        rl_go = (mode_q != MODE_OFF);
      end
    end else if (cmd_run_i) begin
      if (!(mode_q == MODE_OFF && per_q == '0)) begin
        a_mode = run_once_i ? MODE_ONESHOT : MODE_PERIODIC;
        rl_go  = (mode_q == MODE_OFF);
      end
    end else if (mode_q != MODE_OFF && tick_i && per_q != '0) begin
      a_fresh = 1'b0;
      if (({1'b0, pc_q} + 1'b1) < {1'b0, per_q}) begin
        a_pc = pc_q + 1'b1;
      end else begin
        a_pc = '0;
        if (rem_q > {{CNT_W{1'b0}}, 1'b1}) begin
          a_rem = rem_q - 1'b1;
        end else if (mode_q == MODE_ONESHOT) begin
          a_cnt  = '0;
          a_mode = MODE_OFF;
          a_trig = 1'b1;
        end else begin
          rl_adj = (cnt_q == '0 || lim_q == '0) ? ADJ_NONE : ADJ_PLUS;
          a_trig = pol_q.no_imm_trig || (cnt_q != '0 && lim_q != '0);
          a_cnt  = lim_q;
          rl_go  = 1'b1;
        end
      end
    end
  end

  pdt_reload #(.CNT_W(CNT_W)) u_rl (
    .cnt_i (a_cnt), .lim_i (a_lim), .mode_i (a_mode), .per_zero_i (a_per == '0),
    .adj_i (rl_adj), .pol_i (pol_q),
    .cnt_o (rl_cnt), .rem_o (rl_rem), .off_o (rl_off), .trig_o (rl_trig)
  );

  // Stage B: apply reload
  always_comb begin
    n_mode  = a_mode;
    n_cnt   = a_cnt;
    n_pc    = a_pc;
    n_rem   = a_rem;
    n_fresh = a_fresh;
    n_trig  = a_trig;
    if (rl_go) begin
      n_cnt   = rl_cnt;
      n_trig  = a_trig | rl_trig;
      n_pc    = '0;
      n_fresh = 1'b1;
      if (rl_off) n_mode = MODE_OFF;
      else        n_rem  = rl_rem;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q  <= MODE_OFF;
      cnt_q   <= '0;
      lim_q   <= '0;
      per_q   <= {{(PER_W-1){1'b0}}, 1'b1};
      pc_q    <= '0;
      rem_q   <= '0;
      fresh_q <= 1'b1;
      trig_q  <= 1'b0;
      pol_q   <= pol_t'(policy_i);
    end else begin
      mode_q  <= n_mode;
      cnt_q   <= n_cnt;
      lim_q   <= a_lim;
      per_q   <= a_per;
      pc_q    <= n_pc;
      rem_q   <= n_rem;
      fresh_q <= n_fresh;
      trig_q  <= n_trig;
    end
  end

  assign count_o = rb;
  assign mode_o  = mode_q;
  assign trig_o  = trig_q;
endmodule

// File: rtl/pdt_chk.sv
module pdt_chk #(
  parameter int CNT_W = 32,
  parameter int PER_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick_i,
  input logic             cmd_run_i,
  input logic             cmd_stop_i,
  input logic             cmd_count_i,
  input logic             cmd_limit_i,
  input logic             limit_reload_i,
  input logic             cmd_period_i,
  input logic [PER_W-1:0] period_i,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W:0]   rem_q,
  input logic [PER_W-1:0] per_q,
  input logic [PER_W-1:0] pc_q,
  input logic [CNT_W-1:0] count_o,
  input logic             trig_o
);
  logic any_cmd, last_tick;
  assign any_cmd   = cmd_run_i | cmd_stop_i | cmd_count_i | cmd_limit_i | cmd_period_i;
  assign last_tick = tick_i && (({1'b0, pc_q} + 1'b1) >= {1'b0, per_q});

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (count_o == '0 && !trig_o && mode_q == 2'd0));

  a_r2_oneshot_expiry: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q == 2'd2 && !any_cmd && last_tick && rem_q == 1)
      |=> (mode_q == 2'd0 && trig_o && cnt_q == '0));

  a_r4_zero_period_run_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_run_i && !cmd_stop_i && !cmd_period_i && !cmd_count_i && !cmd_limit_i &&
     mode_q == 2'd0 && per_q == '0) |=> (mode_q == 2'd0));

  a_r4_zero_period_disables: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_period_i && !cmd_stop_i && period_i == '0) |=> (mode_q == 2'd0));

  a_r9_live_remainder: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q != 2'd0) |-> (rem_q != '0));

  a_r10_stop_disables: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_stop_i |=> (mode_q == 2'd0));

  a_r10_limit_keeps_count: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_limit_i && !limit_reload_i && !cmd_stop_i && !cmd_period_i && !cmd_count_i)
      |=> ($stable(cnt_q) && $stable(mode_q)));

  a_r12_one_command: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({cmd_run_i, cmd_stop_i, cmd_count_i, cmd_limit_i, cmd_period_i}));
endmodule

bind pdt_timer pdt_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk_i (clk_i), .rst_i (rst_i), .tick_i (tick_i),
  .cmd_run_i (cmd_run_i), .cmd_stop_i (cmd_stop_i), .cmd_count_i (cmd_count_i),
  .cmd_limit_i (cmd_limit_i), .limit_reload_i (limit_reload_i),
  .cmd_period_i (cmd_period_i), .period_i (period_i),
  .mode_q (mode_q), .cnt_q (cnt_q), .rem_q (rem_q), .per_q (per_q), .pc_q (pc_q),
  .count_o (count_o), .trig_o (trig_o)
);

// File: tb/pdt_timer_tb_top.sv
module pdt_timer_tb_top;
  localparam int W = 8;
  localparam int PW = 3;
  localparam int MASK = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] policy = '0;
  logic tick = 0, c_run = 0, once = 0, c_stop = 0, c_cnt = 0, c_lim = 0, lim_rl = 0, c_per = 0;
  logic [W-1:0] wdata = '0;
  logic [PW-1:0] per_in = '0;
  logic [W-1:0] count;
  logic [1:0] mode;
  logic trig;

  always #10 clk = ~clk;

  pdt_timer #(.CNT_W(W), .PER_W(PW)) dut_i (
    .clk_i (clk), .rst_i (rst), .policy_i (policy), .tick_i (tick),
    .cmd_run_i (c_run), .run_once_i (once), .cmd_stop_i (c_stop),
    .cmd_count_i (c_cnt), .cmd_limit_i (c_lim), .limit_reload_i (lim_rl),
    .cmd_period_i (c_per), .wdata_i (wdata), .period_i (per_in),
    .count_o (count), .mode_o (mode), .trig_o (trig)
  );

  int n_tests = 0, n_fail = 0;
  string cur = "R1";
  bit done = 0;

  // behavioural model
  int m_mode, m_cnt, m_lim, m_per, m_pc, m_rem;
  bit m_fresh, m_trig;
  bit p_nit, p_nir, p_wrap, p_cont, p_nrd;

  function automatic int m_read();
    int f;
    if (m_mode != 0 && m_cnt != 0) begin
      f = m_rem - ((m_pc != 0) ? 1 : 0);
      if (p_wrap && m_mode == 1 && m_cnt == m_lim &&
          (m_fresh ? (f == m_lim + 1) : (f == m_lim))) return 0;
      return (f + ((p_nrd && !m_fresh) ? 1 : 0)) & MASK;
    end
    return m_cnt;
  endfunction

  task automatic m_reload(input int adj);  // 0 none-added, 1 plus, 2 skip
    int d;
    if (m_cnt == 0 && !p_nit) m_trig = 1;
    if (m_cnt == 0 && !p_nir) m_cnt = m_lim;
    d = m_cnt + ((p_wrap && adj == 1) ? 1 : 0);
    if (d == 0 && p_cont && m_mode == 1 && m_lim == 0) d = 1;
    if (d == 0 && p_nit && adj != 2) d = 1;
    if (d == 0 && p_nir && m_mode == 1 && m_lim != 0) d = 1;
    m_pc = 0;
    m_fresh = 1;
    if (m_per == 0 || d == 0) m_mode = 0;
    else m_rem = d;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_lim = 0; m_per = 1; m_pc = 0; m_rem = 0;
      m_fresh = 1; m_trig = 0;
      {p_nrd, p_cont, p_wrap, p_nir, p_nit} = policy;
    end else begin
      int rb;
      rb = m_read();
      m_trig = 0;
      if (c_stop) begin
        if (m_mode != 0) begin m_cnt = rb; m_mode = 0; end
      end else if (c_per) begin
        m_cnt = rb; m_per = int'(per_in);
        if (m_mode != 0) m_reload(0);
      end else if (c_cnt) begin
        m_cnt = int'(wdata);
        if (m_mode != 0) m_reload(0);
      end else if (c_lim) begin
        m_lim = int'(wdata);
        if (lim_rl) begin
          m_cnt = m_lim;
          if (m_mode != 0) m_reload(0);
        end
      end else if (c_run) begin
        if (!(m_mode == 0 && m_per == 0)) begin
          bit was_off;
          was_off = (m_mode == 0);
          m_mode = once ? 2 : 1;
          if (was_off) m_reload(0);
        end
      end else if (m_mode != 0 && tick && m_per != 0) begin
        m_fresh = 0;
        m_pc++;
        if (m_pc >= m_per) begin
          m_pc = 0;
          if (m_rem > 1) m_rem--;
          else if (m_mode == 2) begin
            m_cnt = 0; m_mode = 0; m_trig = 1;
          end else begin
            int adj;
            adj = (m_cnt == 0 || m_lim == 0) ? 2 : 1;
            if (p_nit || adj == 1) m_trig = 1;
            m_cnt = m_lim;
            m_reload(adj);
          end
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_tests++;
      if (int'(count) != m_read() || int'(trig) != int'(m_trig) || int'(mode) != m_mode) begin
        n_fail++;
        $display("FAIL %s per-cycle: count=%0d trig=%0d mode=%0d expected count=%0d trig=%0d mode=%0d",
                 cur, count, trig, mode, m_read(), m_trig, m_mode);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] p);
    @(negedge clk);
    rst = 1; policy = p;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic set_count(input int v);
    @(negedge clk); c_cnt = 1; wdata = W'(v);
    @(negedge clk); c_cnt = 0;
  endtask

  task automatic set_limit(input int v, input bit rl);
    @(negedge clk); c_lim = 1; lim_rl = rl; wdata = W'(v);
    @(negedge clk); c_lim = 0; lim_rl = 0;
  endtask

  task automatic set_period(input int v);
    @(negedge clk); c_per = 1; per_in = PW'(v);
    @(negedge clk); c_per = 0;
  endtask

  task automatic run(input bit os);
    @(negedge clk); c_run = 1; once = os;
    @(negedge clk); c_run = 0; once = 0;
  endtask

  task automatic stop();
    @(negedge clk); c_stop = 1;
    @(negedge clk); c_stop = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cur = "R1";
    do_reset(5'b00000);
    check("R1", int'(count), 0, "count after reset");
    check("R1", int'(mode), 0, "mode after reset");
    check("R1", int'(trig), 0, "trig after reset");

    // R2 one-shot
    cur = "R2";
    set_count(3);
    check("R2", int'(count), 3, "count loaded while disabled");
    run(1);
    check("R2", int'(mode), 2, "one-shot mode code");
    check("R2", int'(count), 3, "fresh one-shot count");
    ticks(3);
    check("R2", int'(mode), 0, "one-shot expiry disables");
    check("R2", int'(trig), 1, "one-shot trigger");
    check("R2", int'(count), 0, "one-shot count cleared");
    @(negedge clk);
    check("R13", int'(trig), 0, "trigger lasts one cycle");

    // R3 periodic with interval 2, R11 floor
    cur = "R3";
    set_period(2);
    set_limit(3, 1);
    run(0);
    check("R3", int'(mode), 1, "periodic mode code");
    ticks(3);
    check("R11", int'(count), 1, "floored count part-way through step");
    ticks(3);
    check("R3", int'(trig), 1, "periodic expiry trigger");
    check("R3", int'(count), 3, "periodic reload from limit");
    check("R3", int'(mode), 1, "periodic stays enabled");

    // R4 zero interval
    cur = "R4";
    do_reset(5'b00000);
    set_period(2);
    set_limit(6, 1);
    run(0);
    ticks(3);
    set_period(0);
    check("R4", int'(mode), 0, "zero interval disables");
    check("R4", int'(count), 4, "zero interval latches count");
    run(0);
    check("R4", int'(mode), 0, "run ignored with zero interval");
    set_period(1);
    run(0);
    check("R4", int'(mode), 1, "run accepted after interval restored");

    // R5 immediate trigger on zero count
    cur = "R5";
    do_reset(5'b00000);
    set_limit(5, 0);
    run(0);
    check("R5", int'(trig), 1, "zero count start triggers");
    check("R6", int'(count), 5, "zero count takes limit");
    cur = "R5";
    do_reset(5'b00001);
    set_limit(5, 0);
    run(0);
    check("R5", int'(trig), 0, "no immediate trigger policy");
    check("R5", int'(count), 5, "count with no immediate trigger");

    // R6 deferred reload
    cur = "R6";
    do_reset(5'b00010);
    set_limit(4, 0);
    run(0);
    check("R6", int'(trig), 1, "deferred reload start triggers");
    check("R6", int'(count), 0, "count held at zero");
    check("R6", int'(mode), 1, "stays periodic");
    ticks(1);
    check("R6", int'(trig), 0, "deferred reload no retrigger");
    check("R6", int'(count), 4, "deferred reload loads limit");

    // R7 wrap
    cur = "R7";
    do_reset(5'b00100);
    set_limit(2, 1);
    run(0);
    check("R7", int'(count), 2, "first period count");
    ticks(2);
    check("R7", int'(trig), 1, "first wrap trigger");
    check("R7", int'(count), 0, "held zero after wrap");
    ticks(1);
    check("R7", int'(count), 0, "still zero one step later");
    ticks(1);
    check("R7", int'(count), 1, "counting down after hold");
    ticks(1);
    check("R7", int'(trig), 1, "second wrap after limit+1 steps");

    // R8 continuous trigger
    cur = "R8";
    do_reset(5'b01000);
    set_limit(0, 1);
    run(0);
    check("R8", int'(trig), 1, "zero limit start triggers");
    check("R8", int'(mode), 1, "zero limit stays periodic");
    for (int i = 0; i < 3; i++) begin
      ticks(1);
      check("R8", int'(trig), 1, "trigger every step");
      check("R8", int'(mode), 1, "mode kept");
    end

    // R9 self-disable
    cur = "R9";
    do_reset(5'b00000);
    set_limit(0, 1);
    run(0);
    check("R9", int'(mode), 0, "zero effective count disables");
    check("R9", int'(trig), 1, "zero count trigger before disable");

    // R10 stop and limit
    cur = "R10";
    do_reset(5'b00000);
    set_limit(10, 1);
    run(0);
    ticks(4);
    check("R10", int'(count), 6, "count before stop");
    stop();
    check("R10", int'(mode), 0, "stop disables");
    check("R10", int'(count), 6, "stop latches count");
    set_limit(20, 0);
    check("R10", int'(count), 6, "limit without reload leaves count");
    set_limit(7, 1);
    check("R10", int'(count), 7, "limit with reload sets count");

    // R11 no round-down
    cur = "R11";
    do_reset(5'b10000);
    set_limit(5, 1);
    run(0);
    check("R11", int'(count), 5, "fresh read not bumped");
    ticks(1);
    check("R11", int'(count), 5, "bumped read after step");
    ticks(1);
    check("R11", int'(count), 4, "bumped read second step");

    // R12 command beats tick
    cur = "R12";
    do_reset(5'b00000);
    set_limit(10, 1);
    run(0);
    @(negedge clk); tick = 1; c_cnt = 1; wdata = 8'd4;
    @(negedge clk); tick = 0; c_cnt = 0;
    check("R12", int'(count), 4, "tick dropped under command");
    ticks(1);
    check("R12", int'(count), 3, "tick resumes after command");

    // R3 long periodic run at top of range
    cur = "R3";
    set_limit(255, 1);
    ticks(255);
    check("R3", int'(trig), 1, "full-range expiry");
    check("R3", int'(count), 255, "full-range reload");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule